// File: doc/BRIEF.md
# Flag Threshold Offset Loader

This block stores the two threshold offsets that a FIFO's flag logic compares against its fill level. One offset sets how close to empty the almost-empty flag fires, and the other sets how close to full the almost-full flag fires. On a master reset, the level of the load-select input picks two things: the default values of both offsets and the one way they may be rewritten afterwards. That way is either a parallel write from the data bus or a bit-serial shift through the pin that also picks the FIFO operating mode during reset.

Both offsets are driven on their own outputs all the time. Software can also read them back in turn over a registered read port, whichever loading method is active. A partial reset restarts any load or read sequence that is under way. It keeps the stored offsets, the loading method and the latched FIFO mode. Both resets are active low and are sampled on the rising clock edge.

Top module: `flag_offset_loader`

## Requirements
- R1: A master reset with `load_sel` low sets both offsets to 0x07F and enables only parallel loading.
- R2: A master reset with `load_sel` high sets both offsets to 0x3FF and enables only serial loading.
- R3: In parallel loading, each `pwr_en` cycle stores `din` in one offset, alternating between them. The first strobe after a reset writes the almost-empty offset and the next writes the almost-full offset. The new value appears on `ae_ofs` or `af_ofs` after that clock edge.
- R4: In serial loading, each `ser_en` cycle shifts in one bit from `mode_si`. Twenty bits make one load: the almost-empty offset comes first and then the almost-full offset, each least significant bit first. Both offsets change together on the edge that takes the twentieth bit and stay unchanged before it.
- R5: Each `rd_en` cycle places one offset on `dout`, which is valid after that clock edge. Reads alternate starting with the almost-empty offset. `dout` holds its value when `rd_en` is low. Read-back works under either loading method.
- R6: A partial reset keeps both offsets and the loading method. It restarts the parallel write order, the read order and the serial bit count from their first position.
- R7: A load attempt through the method that was not selected at master reset leaves both offsets unchanged.
- R8: `fwft_mode` takes the level of `mode_si` at master reset. A partial reset and later serial traffic on that pin do not change it.
- R9: `dout` is zero after a master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| load_sel | input | 1 | Chooses the loading method and default offsets during master reset |
| mode_si | input | 1 | FIFO mode select during master reset; serial offset data afterwards |
| ser_en | input | 1 | Shifts in one serial bit |
| pwr_en | input | 1 | Parallel write strobe |
| din | input | 10 | Parallel offset data |
| rd_en | input | 1 | Read-back strobe |
| dout | output | 10 | Read-back data |
| ae_ofs | output | 10 | Almost-empty offset |
| af_ofs | output | 10 | Almost-full offset |
| fwft_mode | output | 1 | FIFO mode latched at master reset |

## Verification
The properties assume that `load_sel` and `mode_si` are steady across each master-reset cycle. They also assume that no load or read strobe is counted while either reset is asserted, so a hold check can treat any offset change as coming from the selected method alone. The stimulus changes inputs only on falling edges and drops every strobe before it asserts a reset. Serial words are always driven by the bench bit by bit on `mode_si`. A partial reset is issued once in the middle of a serial word to check that the bit count restarts.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int OFS_W = 10,
  parameter logic [OFS_W-1:0] DEF_PAR = 'h07F,
  parameter logic [OFS_W-1:0] DEF_SER = 'h3FF
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             load_sel,
  input  logic             mode_si,
  input  logic             ser_en,
  input  logic             pwr_en,
  input  logic [OFS_W-1:0] din,
  input  logic             rd_en,
  output logic [OFS_W-1:0] dout,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic             fwft_mode
);
  localparam int SH_W  = 2 * OFS_W;
  localparam int CNT_W = $clog2(SH_W);

  logic             ser_method;
  logic [SH_W-1:0]  shreg;
  logic [CNT_W-1:0] bit_cnt;
  logic             wsel, rsel;

  wire [SH_W-1:0] sh_next  = {mode_si, shreg[SH_W-1:1]};
  wire            ser_go   = ser_method & ser_en;
  wire            ser_last = ser_go && (bit_cnt == CNT_W'(SH_W - 1));
  wire            par_go   = ~ser_method & pwr_en;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ser_method <= load_sel;
      ae_ofs     <= load_sel ? DEF_SER : DEF_PAR;
      af_ofs     <= load_sel ? DEF_SER : DEF_PAR;
      fwft_mode  <= mode_si;
      shreg      <= '0;
      bit_cnt    <= '0;
      wsel       <= 1'b0;
      rsel       <= 1'b0;
      dout       <= '0;
    end else if (!prst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      wsel    <= 1'b0;
      rsel    <= 1'b0;
    end else begin
      if (ser_go) begin
        shreg   <= sh_next;
        bit_cnt <= ser_last ? '0 : bit_cnt + 1'b1;
      end
      if (ser_last) begin
        ae_ofs <= sh_next[OFS_W-1:0];
        af_ofs <= sh_next[SH_W-1:OFS_W];
      end
      if (par_go) begin
        wsel <= ~wsel;
        if (wsel) af_ofs <= din;
        else      ae_ofs <= din;
      end
      if (rd_en) begin
        rsel <= ~rsel;
        dout <= rsel ? af_ofs : ae_ofs;
      end
    end
  end
endmodule

// File: rtl/flag_offset_loader_chk.sv
module flag_offset_loader_chk #(
  parameter int OFS_W = 10,
  parameter logic [OFS_W-1:0] DEF_PAR = 'h07F,
  parameter logic [OFS_W-1:0] DEF_SER = 'h3FF
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             prst_n,
  input logic             load_sel,
  input logic             mode_si,
  input logic             ser_en,
  input logic             pwr_en,
  input logic             rd_en,
  input logic [OFS_W-1:0] dout,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs,
  input logic             fwft_mode,
  input logic             ser_method
);
  p_par_default_r1: assert property (@(posedge clk) disable iff (!mrst_n)
    ($rose(mrst_n) && !$past(load_sel)) |->
      (ae_ofs == DEF_PAR && af_ofs == DEF_PAR && !ser_method));

  p_ser_default_r2: assert property (@(posedge clk) disable iff (!mrst_n)
    ($rose(mrst_n) && $past(load_sel)) |->
      (ae_ofs == DEF_SER && af_ofs == DEF_SER && ser_method));

  p_par_hold_r3: assert property (@(posedge clk) disable iff (!mrst_n)
    (!ser_method && !pwr_en) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  p_ser_hold_r4: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_method && !ser_en) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  p_dout_hold_r5: assert property (@(posedge clk) disable iff (!mrst_n)
    !rd_en |=> $stable(dout));

  p_partial_keep_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(ser_method)));

  p_mode_latch_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(mrst_n) |-> (fwft_mode == $past(mode_si)));

  p_mode_keep_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    !$rose(mrst_n) |-> $stable(fwft_mode));

  p_dout_zero_r9: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(mrst_n) |-> (dout == '0));
endmodule

bind flag_offset_loader flag_offset_loader_chk #(
  .OFS_W(OFS_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
) u_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .load_sel(load_sel),
  .mode_si(mode_si), .ser_en(ser_en), .pwr_en(pwr_en), .rd_en(rd_en),
  .dout(dout), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .fwft_mode(fwft_mode),
  .ser_method(ser_method)
);

// File: tb/flag_offset_loader_bench.sv
module flag_offset_loader_bench;
  localparam int CLK_P = 10;
  localparam int W = 10;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, load_sel = 1'b0, mode_si = 1'b0;
  logic ser_en = 1'b0, pwr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout, ae_ofs, af_ofs;
  logic fwft_mode;

  int checks = 0, errors = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;
  logic m_rsel = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  flag_offset_loader u_flag_offset_loader (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .load_sel(load_sel),
    .mode_si(mode_si), .ser_en(ser_en), .pwr_en(pwr_en), .din(din),
    .rd_en(rd_en), .dout(dout), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .fwft_mode(fwft_mode)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic mreset(logic ls, logic si);
    mrst_n = 1'b0; load_sel = ls; mode_si = si;
    tick();
    mrst_n = 1'b1; mode_si = 1'b0;
    m_rsel = 1'b0;
  endtask

  task automatic preset();
    prst_n = 1'b0;
    tick();
    prst_n = 1'b1;
    m_rsel = 1'b0;
  endtask

  task automatic pwrite(logic [W-1:0] v);
    pwr_en = 1'b1; din = v;
    tick();
    pwr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [W-1:0] exp_ae, logic [W-1:0] exp_af);
    exp_q.push_back(m_rsel ? exp_af : exp_ae);
    tag_q.push_back(req);
    m_rsel = ~m_rsel;
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic sbits(logic [W-1:0] e, logic [W-1:0] f, int first, int count);
    for (int i = first; i < first + count; i++) begin
      mode_si = (i < W) ? e[i] : f[i-W];
      ser_en = 1'b1;
      tick();
    end
    ser_en = 1'b0;
    mode_si = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en && mrst_n && prst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected read", 1, 0);
      end else begin
        chk(tag_q.pop_front(), dout, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick();
    mreset(1'b0, 1'b1);
    chk("R1 ae default", ae_ofs, 'h07F);
    chk("R1 af default", af_ofs, 'h07F);
    chk("R8 mode latched high", fwft_mode, 1);
    chk("R9 dout cleared", dout, 0);
    rd("R5 read ae default", 'h07F, 'h07F);
    rd("R5 read af default", 'h07F, 'h07F);

    pwrite('h155);
    chk("R3 first strobe ae", ae_ofs, 'h155);
    chk("R3 af untouched", af_ofs, 'h07F);
    pwrite('h0AA);
    chk("R3 second strobe af", af_ofs, 'h0AA);
    rd("R5 read ae parallel", 'h155, 'h0AA);
    rd("R5 read af parallel", 'h155, 'h0AA);

    sbits('h3C3, 'h111, 0, 2*W);
    chk("R7 serial ignored ae", ae_ofs, 'h155);
    chk("R7 serial ignored af", af_ofs, 'h0AA);
    chk("R8 serial traffic keeps mode", fwft_mode, 1);

    pwrite('h012);
    preset();
    chk("R6 ae kept", ae_ofs, 'h012);
    chk("R6 af kept", af_ofs, 'h0AA);
    chk("R8 partial keeps mode", fwft_mode, 1);
    pwrite('h034);
    chk("R6 write order restarted ae", ae_ofs, 'h034);
    chk("R6 write order restarted af", af_ofs, 'h0AA);
    rd("R6 read before partial", 'h034, 'h0AA);
    preset();
    rd("R6 read order restarted", 'h034, 'h0AA);
    repeat (2) tick();

    mreset(1'b1, 1'b0);
    chk("R2 ae default", ae_ofs, 'h3FF);
    chk("R2 af default", af_ofs, 'h3FF);
    chk("R8 mode latched low", fwft_mode, 0);
    chk("R9 dout cleared again", dout, 0);
    pwrite('h001);
    chk("R7 parallel ignored ae", ae_ofs, 'h3FF);
    chk("R7 parallel ignored af", af_ofs, 'h3FF);
    rd("R5 read ae serial method", 'h3FF, 'h3FF);

    sbits('h2A5, 'h15A, 0, 2*W-1);
    chk("R4 ae held before last bit", ae_ofs, 'h3FF);
    chk("R4 af held before last bit", af_ofs, 'h3FF);
    sbits('h2A5, 'h15A, 2*W-1, 1);
    chk("R4 ae committed", ae_ofs, 'h2A5);
    chk("R4 af committed", af_ofs, 'h15A);
    rd("R5 read af serial method", 'h2A5, 'h15A);
    rd("R5 read ae serial method", 'h2A5, 'h15A);

    sbits('h0F0, 'h30F, 0, 5);
    preset();
    chk("R6 serial offsets kept", ae_ofs, 'h2A5);
    sbits('h0F0, 'h30F, 0, 2*W);
    chk("R6 serial count restarted ae", ae_ofs, 'h0F0);
    chk("R6 serial count restarted af", af_ofs, 'h30F);
    pwrite('h001);
    chk("R6 method kept after partial", ae_ofs, 'h0F0);
    chk("R8 mode still low", fwft_mode, 0);

    repeat (2) tick();
    chk("R5 all reads seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule